// File: doc/BRIEF.md
# Three-Channel Interval Timer

This block holds three independent 16-bit down-counters that share one count-enable strobe, normally a 2 MHz tick derived from the system clock. Software programs it through an 8-bit write port that has four addresses. Address 3 takes a control word that configures one channel. Addresses 0 to 2 take count bytes for channels 0 to 2. When a channel's count expires, it raises a one-cycle terminal-count pulse on its own output, which feeds the matching input of an interrupt controller.

Each channel runs in one of two ways. In one-shot mode it pulses once and stops. In square-wave mode it reloads the programmed count and pulses again at each expiry. A count may be loaded as a low/high byte pair or as a single high byte. The BCD bit is stored for each channel and shown on a flag output as an unsupported setting. Counting always stays binary.

Top module: `interval_timer3`

## Requirements
- R1: Control word bits are select [7:6], load format [5:4], mode [3:1] and BCD [0]. A read at address 3 returns the last control word written (0 after reset). Reads at addresses 0 to 2 return 0.
- R2: A control write with select 0 to 2 stops that channel, clears its terminal-count pulse and restarts its byte sequencer, so the next data write is taken as the first byte. Select value 3 configures no channel.
- R3: With load format 3, the first data write is the low byte and the second is the high byte. The channel starts after the second byte, and the sequencer then expects a low byte again.
- R4: With load format 2, one data write loads the high byte with a zero low byte, and the channel starts at once.
- R5: With load format 0 or 1, data writes are ignored and the channel stays idle.
- R6: A loaded count N expires on the Nth tick, counted only in cycles where tick_i is high. tc_o for that channel is then high for exactly the cycle after that tick.
- R7: Mode value 0 (any value other than 3) is one-shot: exactly one pulse per load, then the channel stops.
- R8: Mode value 3 reloads N at each expiry and pulses every N ticks.
- R9: Control bit 0 is copied to bcd_o of the selected channel, and counting stays binary.
- R10: While rst_ni is low, tc_o, bcd_o and rdata_o are 0 and all channels are idle.
- R11: Channels count independently and may run at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Shared count enable |
| wr_i | input | 1 | Write strobe |
| addr_i | input | 2 | 0-2 channel data, 3 control |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i (combinational) |
| tc_o | output | 3 | Per-channel terminal-count pulse |
| bcd_o | output | 3 | Per-channel BCD-requested flag |

## Verification
Each write is captured at a single clock edge. A count starts at the edge that captures its last byte, and tc_o rises one register stage after the Nth tick that follows. With tick_i held high, the pulse is therefore seen at the Nth falling edge after the loading edge. In square-wave mode the next pulse comes N falling edges later. The bench drives inputs on falling edges and numbers the falling edges from the loading write. It records the first and second pulse positions for each channel and compares them with N and 2N (or with none). rdata_o and bcd_o are sampled at the falling edge after the capturing edge.

// File: rtl/itimer_pkg.sv
package itimer_pkg;
  typedef enum logic [1:0] {
    FMT_NONE = 2'd0,
    FMT_LOW  = 2'd1,
    FMT_HIGH = 2'd2,
    FMT_PAIR = 2'd3
  } ld_fmt_e;

  typedef struct packed {
    logic [1:0] sel;
    ld_fmt_e    fmt;
    logic [2:0] mode;
    logic       bcd;
  } ctrl_word_t;

  localparam logic [2:0] MODE_SQUARE = 3'd3;
  localparam logic [1:0] CTRL_ADDR   = 2'd3;
endpackage

// File: rtl/itimer_port_dec.sv
module itimer_port_dec
  import itimer_pkg::*;
#(
  parameter int unsigned NUM_CH = 3,
  parameter int unsigned BUS_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [1:0]        addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [BUS_W-1:0]  ctrl_q_o,
  output logic [NUM_CH-1:0] cfg_wr_o,
  output logic [NUM_CH-1:0] data_wr_o
);
  ctrl_word_t cw;
  assign cw = ctrl_word_t'(wdata_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q_o <= '0;
    else if (wr_i && addr_i == CTRL_ADDR) ctrl_q_o <= wdata_i;
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_dec
    assign cfg_wr_o[ch]  = wr_i && addr_i == CTRL_ADDR && cw.sel == 2'(ch);
    assign data_wr_o[ch] = wr_i && addr_i == 2'(ch);
  end
endmodule

// File: rtl/itimer_chan.sv
module itimer_chan
  import itimer_pkg::*;
#(
  parameter int unsigned BUS_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             cfg_wr_i,
  input  ctrl_word_t       cfg_i,
  input  logic             data_wr_i,
  input  logic [BUS_W-1:0] data_i,
  output logic             tc_o,
  output logic             bcd_o
);
  localparam int unsigned CNT_W = 2 * BUS_W;

  ld_fmt_e          fmt_q;
  logic [2:0]       mode_q;
  logic             hi_next_q;
  logic [BUS_W-1:0] lo_q;
  logic [CNT_W-1:0] cnt_q, reload_q, load_val;
  logic             run_q, load;

  always_comb begin
    load     = 1'b0;
    load_val = {data_i, lo_q};
    if (data_wr_i && fmt_q == FMT_PAIR && hi_next_q) load = 1'b1;
    if (data_wr_i && fmt_q == FMT_HIGH) begin
      load     = 1'b1;
      load_val = {data_i, {BUS_W{1'b0}}};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fmt_q     <= FMT_NONE;
      mode_q    <= '0;
      bcd_o     <= 1'b0;
      hi_next_q <= 1'b0;
      lo_q      <= '0;
      cnt_q     <= '0;
      reload_q  <= '0;
      run_q     <= 1'b0;
      tc_o      <= 1'b0;
    end else begin
      tc_o <= 1'b0;
      if (cfg_wr_i) begin
        fmt_q     <= cfg_i.fmt;
        mode_q    <= cfg_i.mode;
        bcd_o     <= cfg_i.bcd;  // flagged only; counting stays binary
        hi_next_q <= 1'b0;
        run_q     <= 1'b0;
      end else if (load) begin
        cnt_q     <= load_val;
        reload_q  <= load_val;
        run_q     <= 1'b1;
        hi_next_q <= 1'b0;
      end else begin
        if (data_wr_i && fmt_q == FMT_PAIR) begin
          lo_q      <= data_i;
          hi_next_q <= 1'b1;
        end
        if (run_q && tick_i) begin
          if (cnt_q == CNT_W'(1)) begin
            tc_o <= 1'b1;
            if (mode_q == MODE_SQUARE) cnt_q <= reload_q;
            else begin
              cnt_q <= '0;
              run_q <= 1'b0;
            end
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end
      end
    end
  end
endmodule

// File: rtl/interval_timer3.sv
module interval_timer3
  import itimer_pkg::*;
#(
  parameter int unsigned NUM_CH = 3,
  parameter int unsigned BUS_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_i,
  input  logic [1:0]        addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [BUS_W-1:0]  rdata_o,
  output logic [NUM_CH-1:0] tc_o,
  output logic [NUM_CH-1:0] bcd_o
);
  logic [BUS_W-1:0]  ctrl_q;
  logic [NUM_CH-1:0] cfg_wr, data_wr;

  itimer_port_dec #(.NUM_CH(NUM_CH), .BUS_W(BUS_W)) i_dec (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .ctrl_q_o  (ctrl_q),
    .cfg_wr_o  (cfg_wr),
    .data_wr_o (data_wr)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    itimer_chan #(.BUS_W(BUS_W)) i_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .tick_i    (tick_i),
      .cfg_wr_i  (cfg_wr[ch]),
      .cfg_i     (ctrl_word_t'(wdata_i)),
      .data_wr_i (data_wr[ch]),
      .data_i    (wdata_i),
      .tc_o      (tc_o[ch]),
      .bcd_o     (bcd_o[ch])
    );
  end

  assign rdata_o = (addr_i == CTRL_ADDR) ? ctrl_q : '0;
endmodule

// File: rtl/itimer_chk.sv
module itimer_chk #(
  parameter int unsigned NUM_CH = 3,
  parameter int unsigned BUS_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              wr_i,
  input logic [1:0]        addr_i,
  input logic [BUS_W-1:0]  wdata_i,
  input logic [BUS_W-1:0]  rdata_o,
  input logic [NUM_CH-1:0] tc_o,
  input logic [NUM_CH-1:0] bcd_o
);
  p_ctrl_readback_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(wr_i && addr_i == 2'd3) && addr_i == 2'd3) |-> rdata_o == $past(wdata_i));

  p_reset_quiet_r10: assert property (@(posedge clk_i)
    !rst_ni |-> (tc_o == '0 && bcd_o == '0 && rdata_o == '0));

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    p_cfg_stops_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(wr_i && addr_i == 2'd3 && wdata_i[7:6] == 2'(ch)) |-> !tc_o[ch]);

    p_tc_needs_tick_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tc_o[ch] |-> $past(tick_i));

    p_bcd_flag_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && addr_i == 2'd3 && wdata_i[7:6] == 2'(ch)) |=> bcd_o[ch] == $past(wdata_i[0]));
  end
endmodule

bind interval_timer3 itimer_chk #(.NUM_CH(NUM_CH), .BUS_W(BUS_W)) i_itimer_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .tick_i  (tick_i),
  .wr_i    (wr_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .tc_o    (tc_o),
  .bcd_o   (bcd_o)
);

// File: tb/test_interval_timer3.sv
module test_interval_timer3;
  localparam time CLK_PERIOD = 10ns;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b1;
  logic       wr_i = 1'b0;
  logic [1:0] addr_i = 2'd0;
  logic [7:0] wdata_i = 8'd0;
  logic [7:0] rdata_o;
  logic [2:0] tc_o, bcd_o;

  int n_run = 0, n_fail = 0;
  int first_k[3], second_k[3];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  interval_timer3 i_interval_timer3 (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .wr_i(wr_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .tc_o(tc_o), .bcd_o(bcd_o)
  );

  typedef struct packed {
    logic [1:0] ch;
    logic [2:0] mode;
    logic [7:0] cnt;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{2'd0, 3'd0, 8'd5},
    '{2'd1, 3'd3, 8'd4},
    '{2'd2, 3'd0, 8'd9},
    '{2'd0, 3'd3, 8'd7},
    '{2'd1, 3'd0, 8'd1},
    '{2'd2, 3'd3, 8'd1}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // inputs change on falling edges; captured at the next rising edge
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  // falling edge k=1.. after the last write; record first two pulses per channel
  task automatic watch(input int limit);
    for (int c = 0; c < 3; c++) begin first_k[c] = 0; second_k[c] = 0; end
    for (int k = 1; k <= limit; k++) begin
      @(negedge clk_i);
      for (int c = 0; c < 3; c++)
        if (tc_o[c]) begin
          if (first_k[c] == 0) first_k[c] = k;
          else if (second_k[c] == 0) second_k[c] = k;
        end
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk_i);
    // R10: reset state
    rd(2'd3, r);
    check(r == 8'h00 && tc_o == 3'b000 && bcd_o == 3'b000, "R10 reset outputs", int'(r), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // vector table: format 3, tick every cycle (R3 R6 R7 R8)
    for (int i = 0; i < 6; i++) begin
      int n;
      n = int'(VEC[i].cnt);
      wr(2'd3, {VEC[i].ch, 2'b11, VEC[i].mode, 1'b0});
      wr(VEC[i].ch, VEC[i].cnt);
      check(tc_o[VEC[i].ch] == 1'b0, "R3 idle after low byte", int'(tc_o[VEC[i].ch]), 0);
      wr(VEC[i].ch, 8'h00);
      watch(3 * n + 4);
      check(first_k[VEC[i].ch] == n, "R6 first expiry", first_k[VEC[i].ch], n);
      if (VEC[i].mode == 3'd3)
        check(second_k[VEC[i].ch] == 2 * n, "R8 reload period", second_k[VEC[i].ch], 2 * n);
      else
        check(second_k[VEC[i].ch] == 0, "R7 one-shot", second_k[VEC[i].ch], 0);
      wr(2'd3, {VEC[i].ch, 6'b000000});  // stop channel
    end

    // R1: readback and data-address reads
    wr(2'd3, 8'h76);
    rd(2'd3, r);
    check(r == 8'h76, "R1 control readback", int'(r), 'h76);
    rd(2'd0, r);
    check(r == 8'h00, "R1 data address reads zero", int'(r), 0);

    // R4: high-byte-only load, 0x01 -> 256
    wr(2'd3, 8'hA0);
    wr(2'd2, 8'h01);
    watch(300);
    check(first_k[2] == 256, "R4 high byte load", first_k[2], 256);
    check(second_k[2] == 0, "R4 one-shot after high load", second_k[2], 0);

    // R5: format 1 ignores data
    wr(2'd3, 8'h10);
    wr(2'd0, 8'h03);
    wr(2'd0, 8'h00);
    watch(20);
    check(first_k[0] == 0, "R5 format 1 ignored", first_k[0], 0);

    // R2: sequencer restart; 0x08 must be taken as low byte
    wr(2'd3, 8'h30);
    wr(2'd0, 8'h05);
    wr(2'd3, 8'h30);
    wr(2'd0, 8'h08);
    wr(2'd0, 8'h00);
    watch(30);
    check(first_k[0] == 8, "R2 sequencer restart", first_k[0], 8);
    // R2: control write stops a running channel
    wr(2'd0, 8'h0A);
    wr(2'd0, 8'h00);
    repeat (3) @(negedge clk_i);
    wr(2'd3, 8'h30);
    watch(20);
    check(first_k[0] == 0, "R2 control write stops channel", first_k[0], 0);
    // R2: select 3 touches no channel
    wr(2'd3, 8'hF1);
    check(bcd_o == 3'b000, "R2 select 3 no channel", int'(bcd_o), 0);
    rd(2'd3, r);
    check(r == 8'hF1, "R1 readback select 3", int'(r), 'hF1);

    // R9: BCD flagged, counting binary (0x12 -> 18 ticks)
    wr(2'd3, 8'h71);
    check(bcd_o == 3'b010, "R9 bcd flag", int'(bcd_o), 2);
    wr(2'd1, 8'h12);
    wr(2'd1, 8'h00);
    watch(60);
    check(first_k[1] == 18, "R9 binary count with bcd", first_k[1], 18);
    wr(2'd3, 8'h70);
    check(bcd_o == 3'b000, "R9 bcd flag cleared", int'(bcd_o), 0);

    // R6 gating and R11 independence: load with tick low
    tick_i = 1'b0;
    wr(2'd3, 8'h30); wr(2'd0, 8'h03); wr(2'd0, 8'h00);
    wr(2'd3, 8'h70); wr(2'd1, 8'h05); wr(2'd1, 8'h00);
    wr(2'd3, 8'hB6); wr(2'd2, 8'h02); wr(2'd2, 8'h00);
    watch(10);
    check(first_k[0] == 0 && first_k[1] == 0 && first_k[2] == 0,
          "R6 no count without tick", first_k[0] + first_k[1] + first_k[2], 0);
    tick_i = 1'b1;
    watch(12);
    check(first_k[0] == 3, "R11 channel 0", first_k[0], 3);
    check(first_k[1] == 5, "R11 channel 1", first_k[1], 5);
    check(first_k[2] == 2 && second_k[2] == 4, "R11 channel 2 square", second_k[2], 4);

    finish_run();
  end
endmodule